// File: doc/BRIEF.md
# Command-Mode Panel Write Port

This block drives the write side of a parallel 8080-style display bus: an active-low chip select, an active-low write strobe and a data bus. Pixel words arrive on a valid/ready stream and each one becomes a single bus write cycle. The timing of that cycle comes from a configuration word with four phase lengths, each counted in clock cycles: chip-select setup, write setup, strobe active time and hold time. The phase lengths are captured when a frame begins, so they cannot change while that frame is on the bus.

A frame is a programmed number of pixel words. It can be started by software, through a rising edge on a command bit, or by the panel's tearing-effect (TE) pulse. Each source has its own enable. The TE source can be masked, and it can be set to fire on every TE pulse or only on the first pulse after it is armed. While a frame is in flight, any further trigger is dropped and is not queued, because a repeated trigger can reset the panel. When chip select is released after the last word, the block gives a one-cycle frame-done pulse, and the next trigger is accepted from the following cycle. To get frame-done before the next TE pulse, the clock should be at least twice the panel's pixel rate.

Top module: `lcdbus_writer`

## Requirements
- R1: `cfg_word` fields are: chip-select setup at bits 19:16, write setup at 15:12, strobe active at 11:8, hold at 7:4, interface enable at bit 0. The phase fields and `frame_words` are captured in the cycle a frame starts. Later changes do not affect that frame.
- R2: A word cycle runs in this order: one fetch cycle with `pix_ready` high, then write setup for the programmed number of cycles, then `lcd_wr_n` low for the active count, then hold for the hold count. The frame begins with chip-select setup cycles before the first fetch. `lcd_data` stays stable while `lcd_wr_n` is low.
- R3: A strobe active field of 0 gives a one-cycle strobe. Zero setup or hold fields skip that phase completely.
- R4: A frame writes exactly `frame_words` words and releases `lcd_cs_n` right after the last hold phase. A trigger while `frame_words` is 0 starts nothing.
- R5: `frame_done` is a one-cycle pulse in the cycle that `lcd_cs_n` returns high. It occurs only then.
- R6: A rising edge of `trig_ctl[1]` starts a frame when `trig_ctl[0]` is 1. It is ignored when `trig_ctl[0]` is 0.
- R7: A rising edge of `te_in` starts a frame when `trig_ctl[3]` is 1 and `trig_ctl[4]` is 0. Otherwise it is ignored.
- R8: With `trig_ctl[31]` at 1, every TE edge can start a frame. With it at 0, only the first accepted TE edge starts one, until `trig_ctl[3]` is cleared and set again.
- R9: A trigger that arrives while a frame is in progress is dropped. No frame follows from it.
- R10: With `cfg_word[0]` at 0, all triggers are ignored.
- R11: `pix_ready` is high only in fetch cycles. `lcd_data` changes only after a valid/ready handshake.
- R12: `lcd_wr_n` is low only while `lcd_cs_n` is low. The frame starts with `lcd_cs_n` low in the cycle after the trigger edge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 32 | Phase lengths and interface enable |
| trig_ctl | input | 32 | Trigger source selects, software command, TE mask and per-pulse mode |
| frame_words | input | CNT_W | Words per frame |
| te_in | input | 1 | Tearing-effect pulse, synchronous to clk |
| pix_data | input | DATA_W | Pixel word |
| pix_valid | input | 1 | Pixel word available |
| pix_ready | output | 1 | Pixel word accepted this cycle |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_data | output | DATA_W | Panel data bus |
| frame_done | output | 1 | One-cycle frame completion pulse |

## Verification
The assertions check, on every cycle, the invariants of the bus: the strobe stays inside chip select, data holds while the strobe is low, frame-done is a single pulse tied to chip-select release, and data moves only on a handshake. Phase lengths, word counts and trigger acceptance depend on the configuration, so only the bench's scenarios can show them. The bench measures the gaps between edges on the bus for both random and extreme phase settings. It also fires triggers during a frame, with the interface disabled, with a source disabled or masked, and in one-shot TE mode, and then watches for any bus activity.

// File: rtl/lcdbus_pkg.sv
// Shared types and field positions for the panel write port.
// Assumes the configuration word layout listed in the brief.
package lcdbus_pkg;

    localparam int PH_W        = 4;
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_WH_LSB  = 4;
    localparam int CFG_WA_LSB  = 8;
    localparam int CFG_WS_LSB  = 12;
    localparam int CFG_CSS_LSB = 16;

    localparam int TRG_SW_MODE = 0;
    localparam int TRG_SW_CMD  = 1;
    localparam int TRG_HW_EN   = 3;
    localparam int TRG_HW_MASK = 4;
    localparam int TRG_PER_TE  = 31;

    typedef struct packed {
        logic [PH_W-1:0] css;
        logic [PH_W-1:0] ws;
        logic [PH_W-1:0] wa;
        logic [PH_W-1:0] wh;
    } phase_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSS,
        ST_FETCH,
        ST_WSET,
        ST_WACT,
        ST_WHOLD
    } seq_st_t;

    // Pull the phase fields out of the config word; active time of 0 becomes 1.
    function automatic phase_cfg_t unpack_phases(input logic [31:0] w);
        phase_cfg_t p;
        p.css = w[CFG_CSS_LSB +: PH_W];
        p.ws  = w[CFG_WS_LSB  +: PH_W];
        p.wa  = (w[CFG_WA_LSB +: PH_W] == '0) ? PH_W'(1) : w[CFG_WA_LSB +: PH_W];
        p.wh  = w[CFG_WH_LSB  +: PH_W];
        return p;
    endfunction

endpackage

// File: rtl/lcdbus_trig.sv
// Trigger qualifier: turns software command edges and TE edges into a
// single-cycle start pulse. Assumes te_in is already synchronous to clk.
// Drops every trigger while busy is high; nothing is queued.
module lcdbus_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic if_en,
    input  logic frame_ok,
    input  logic sw_mode,
    input  logic sw_cmd,
    input  logic hw_en,
    input  logic hw_mask,
    input  logic per_te,
    input  logic te_in,
    input  logic busy,
    output logic start
);

    logic sw_cmd_q;
    logic te_q;
    logic hw_spent;
    logic sw_hit;
    logic hw_hit;

    // Edge detection of the two trigger sources and the one-shot qualifier.
    always_comb begin
        sw_hit = sw_cmd & ~sw_cmd_q & sw_mode;
        hw_hit = te_in & ~te_q & hw_en & ~hw_mask & (per_te | ~hw_spent);
        start  = if_en & frame_ok & ~busy & (sw_hit | hw_hit);
    end

    // Remember previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_cmd_q <= 1'b0;
            te_q     <= 1'b0;
        end else begin
            sw_cmd_q <= sw_cmd;
            te_q     <= te_in;
        end
    end

    // One-shot TE state: set when a TE edge starts a frame, cleared by disabling TE.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hw_spent <= 1'b0;
        else if (!hw_en)
            hw_spent <= 1'b0;
        else if (start && hw_hit)
            hw_spent <= 1'b1;
    end

endmodule

// File: rtl/lcdbus_seq.sv
// Frame sequencer: walks chip-select setup, then per word fetch / write
// setup / strobe active / hold, for a frame of captured length.
// Assumes start is only pulsed while idle.
module lcdbus_seq #(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       cfg_word,
    input  logic [CNT_W-1:0]  frame_words,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_valid,
    output logic              pix_ready,
    output logic              busy,
    output logic              cs_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] bus_data,
    output logic              frame_done
);
    import lcdbus_pkg::*;

    seq_st_t           st, st_d;
    phase_cfg_t        ph, ph_d;
    logic [PH_W-1:0]   cnt, cnt_d;
    logic [CNT_W-1:0]  left, left_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic              done_q, done_d;

    // Next-state, phase counter and word counter.
    always_comb begin
        phase_cfg_t p_new;
        logic       word_end;
        st_d     = st;
        ph_d     = ph;
        cnt_d    = cnt;
        left_d   = left;
        data_d   = data_q;
        done_d   = 1'b0;
        word_end = 1'b0;
        p_new    = unpack_phases(cfg_word);
        case (st)
            ST_IDLE: begin
                if (start) begin
                    ph_d   = p_new;
                    left_d = frame_words;
                    if (p_new.css != '0) begin
                        st_d  = ST_CSS;
                        cnt_d = p_new.css - PH_W'(1);
                    end else begin
                        st_d = ST_FETCH;
                    end
                end
            end
            ST_CSS: begin
                if (cnt == '0) st_d = ST_FETCH;
                else           cnt_d = cnt - PH_W'(1);
            end
            ST_FETCH: begin
                if (pix_valid) begin
                    data_d = pix_data;
                    left_d = left - CNT_W'(1);
                    if (ph.ws != '0) begin
                        st_d  = ST_WSET;
                        cnt_d = ph.ws - PH_W'(1);
                    end else begin
                        st_d  = ST_WACT;
                        cnt_d = ph.wa - PH_W'(1);
                    end
                end
            end
            ST_WSET: begin
                if (cnt == '0) begin
                    st_d  = ST_WACT;
                    cnt_d = ph.wa - PH_W'(1);
                end else begin
                    cnt_d = cnt - PH_W'(1);
                end
            end
            ST_WACT: begin
                if (cnt == '0) begin
                    if (ph.wh != '0) begin
                        st_d  = ST_WHOLD;
                        cnt_d = ph.wh - PH_W'(1);
                    end else begin
                        word_end = 1'b1;
                    end
                end else begin
                    cnt_d = cnt - PH_W'(1);
                end
            end
            ST_WHOLD: begin
                if (cnt == '0) word_end = 1'b1;
                else           cnt_d = cnt - PH_W'(1);
            end
            default: st_d = ST_IDLE;
        endcase
        if (word_end) begin
            if (left == '0) begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
            end else begin
                st_d = ST_FETCH;
            end
        end
    end

    // State, captured phases, counters, data and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            ph     <= '0;
            cnt    <= '0;
            left   <= '0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            st     <= st_d;
            ph     <= ph_d;
            cnt    <= cnt_d;
            left   <= left_d;
            data_q <= data_d;
            done_q <= done_d;
        end
    end

    // Bus pins decoded straight from the state register.
    always_comb begin
        cs_n       = (st == ST_IDLE);
        wr_n       = (st != ST_WACT);
        pix_ready  = (st == ST_FETCH);
        busy       = (st != ST_IDLE);
        bus_data   = data_q;
        frame_done = done_q;
    end

endmodule

// File: rtl/lcdbus_writer.sv
// Top of the panel write port: trigger qualifier plus frame sequencer.
// Assumes all inputs, te_in included, are synchronous to clk.
module lcdbus_writer #(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic [31:0]       trig_ctl,
    input  logic [CNT_W-1:0]  frame_words,
    input  logic              te_in,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_valid,
    output logic              pix_ready,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic [DATA_W-1:0] lcd_data,
    output logic              frame_done
);
    import lcdbus_pkg::*;

    logic start;
    logic busy;
    logic unused_bits;

    assign unused_bits = ^{cfg_word[31:20], cfg_word[3:1],
                           trig_ctl[30:5], trig_ctl[2]};

    lcdbus_trig u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .if_en    (cfg_word[CFG_EN_BIT]),
        .frame_ok (|frame_words),
        .sw_mode  (trig_ctl[TRG_SW_MODE]),
        .sw_cmd   (trig_ctl[TRG_SW_CMD]),
        .hw_en    (trig_ctl[TRG_HW_EN]),
        .hw_mask  (trig_ctl[TRG_HW_MASK]),
        .per_te   (trig_ctl[TRG_PER_TE]),
        .te_in    (te_in),
        .busy     (busy),
        .start    (start)
    );

    lcdbus_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_word    (cfg_word),
        .frame_words (frame_words),
        .pix_data    (pix_data),
        .pix_valid   (pix_valid),
        .pix_ready   (pix_ready),
        .busy        (busy),
        .cs_n        (lcd_cs_n),
        .wr_n        (lcd_wr_n),
        .bus_data    (lcd_data),
        .frame_done  (frame_done)
    );

endmodule

// File: rtl/lcdbus_writer_chk.sv
// Bus-protocol checker for the panel write port, bound to every instance.
module lcdbus_writer_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic              lcd_cs_n,
    input logic              lcd_wr_n,
    input logic [DATA_W-1:0] lcd_data,
    input logic              frame_done
);

    // R12
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |-> !lcd_cs_n);

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_wr_n && $past(!lcd_wr_n)) |-> $stable(lcd_data));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R5
    done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (lcd_cs_n && !$past(lcd_cs_n)));

    // R5
    release_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_cs_n) |-> frame_done);

    // R11
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> !lcd_cs_n);

    // R11
    data_on_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lcd_data) |-> $past(pix_valid && pix_ready));

endmodule

bind lcdbus_writer lcdbus_writer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .lcd_cs_n   (lcd_cs_n),
    .lcd_wr_n   (lcd_wr_n),
    .lcd_data   (lcd_data),
    .frame_done (frame_done)
);

// File: tb/sim_lcdbus_writer.sv
// Bench for the panel write port: measures phase lengths on the bus.
module sim_lcdbus_writer;

    localparam int DATA_W = 24;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       cfg_word = '0;
    logic [31:0]       trig_ctl = '0;
    logic [CNT_W-1:0]  frame_words = '0;
    logic              te_in = 1'b0;
    logic [DATA_W-1:0] pix_data;
    logic              pix_valid = 1'b1;
    logic              pix_ready;
    logic              lcd_cs_n;
    logic              lcd_wr_n;
    logic [DATA_W-1:0] lcd_data;
    logic              frame_done;

    int n_run  = 0;
    int n_fail = 0;
    int pix_idx = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    function automatic logic [DATA_W-1:0] pat(input int i);
        logic [31:0] v;
        v = (32'(i) * 32'h9E3779B1) ^ 32'h005A_A5C3;
        return v[DATA_W-1:0];
    endfunction

    assign pix_data = pat(pix_idx);

    always @(posedge clk) if (pix_valid && pix_ready) pix_idx <= pix_idx + 1;

    lcdbus_writer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .trig_ctl(trig_ctl),
        .frame_words(frame_words), .te_in(te_in), .pix_data(pix_data),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .lcd_cs_n(lcd_cs_n),
        .lcd_wr_n(lcd_wr_n), .lcd_data(lcd_data), .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Write the trigger control word, passing through zero to re-arm TE one-shot.
    task automatic set_ctl(input logic [31:0] v);
        @(negedge clk) trig_ctl = '0;
        @(negedge clk) trig_ctl = v;
        @(negedge clk);
    endtask

    task automatic launch(input int how);
        if (how == 0) trig_ctl[1] = 1'b1;
        else          te_in = 1'b1;
    endtask

    // Watch for any bus activity over a window after a trigger that must be ignored.
    task automatic expect_quiet(input string req, input string what, input int how);
        int bad = 0;
        @(negedge clk) launch(how);
        for (int c = 1; c <= 40; c++) begin
            @(negedge clk);
            if (c == 1) begin trig_ctl[1] = 1'b0; te_in = 1'b0; end
            if (!lcd_cs_n || pix_ready || frame_done) bad++;
        end
        check(bad == 0, req, what, bad, 0);
    endtask

    // Run one frame, measure every phase on the bus and compare with the requirements.
    task automatic do_frame(input string tag, input int css, input int ws,
                            input int wa, input int wh, input int n,
                            input int how, input bit disturb);
        int c = 0, t_csf = -1, t_csr = -1, t_rise = -1, t_low = -1;
        int nfall = 0, ndone = 0, bad_gap = 0, bad_act = 0, bad_data = 0, bad_pin = 0;
        int first_off = -1, hold_meas = -1, base;
        int wa_e = (wa == 0) ? 1 : wa;
        bit pw = 1'b1;
        @(negedge clk);
        cfg_word    = {12'h0, 4'(css), 4'(ws), 4'(wa), 4'(wh), 3'b000, 1'b1};
        frame_words = CNT_W'(n);
        base        = pix_idx;
        launch(how);
        while (c < 2000) begin
            @(negedge clk);
            c++;
            if (c == 1) begin trig_ctl[1] = 1'b0; te_in = 1'b0; end
            if (disturb && t_csf > 0 && c == t_csf + 1) begin
                cfg_word    = cfg_word ^ 32'h000F_FFF0;
                frame_words = frame_words + CNT_W'(3);
                trig_ctl[0] = 1'b1;
                trig_ctl[1] = 1'b1;
                te_in       = 1'b1;
            end
            if (disturb && t_csf > 0 && c == t_csf + 2) begin
                trig_ctl[1] = 1'b0;
                te_in       = 1'b0;
            end
            if (t_csf < 0 && !lcd_cs_n) t_csf = c;
            if (!lcd_wr_n && lcd_cs_n) bad_pin++;
            if (frame_done) ndone++;
            if (!lcd_wr_n && pw) begin
                nfall++;
                if (nfall == 1) first_off = c - t_csf;
                else if (c - t_rise != wh + 1 + ws) bad_gap++;
                if (lcd_data !== pat(base + nfall - 1)) bad_data++;
                t_low = c;
            end
            if (lcd_wr_n && !pw) begin
                t_rise = c;
                if (c - t_low != wa_e) bad_act++;
            end
            pw = lcd_wr_n;
            if (t_csf >= 0 && lcd_cs_n && t_csr < 0) begin
                t_csr = c;
                hold_meas = c - t_rise;
                if (!frame_done) bad_pin++;
                break;
            end
        end
        check(t_csf == 1, "R12", {tag, " cs start latency"}, t_csf, 1);
        check(first_off == css + 1 + ws, "R2", {tag, " cs fall to first strobe"}, first_off, css + 1 + ws);
        check(bad_act == 0, "R3", {tag, " strobe active length"}, bad_act, 0);
        check(bad_gap == 0, "R2", {tag, " hold+fetch+setup gap"}, bad_gap, 0);
        check(hold_meas == wh, "R4", {tag, " last hold before release"}, hold_meas, wh);
        check(nfall == n, "R4", {tag, " words per frame"}, nfall, n);
        check(bad_data == 0, "R11", {tag, " data order"}, bad_data, 0);
        check(t_csr - t_csf == css + n * (1 + ws + wa_e + wh), "R1",
              {tag, " frame length"}, t_csr - t_csf, css + n * (1 + ws + wa_e + wh));
        check(ndone == 1 && bad_pin == 0, "R5", {tag, " done pulse and pin order"},
              ndone * 10 + bad_pin, 10);
        if (disturb) expect_quiet("R9", {tag, " no frame from mid-frame trigger"}, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 R12 reset state
        check(lcd_cs_n && lcd_wr_n && !frame_done && !pix_ready, "R12", "reset pins",
              {lcd_cs_n, lcd_wr_n, frame_done, pix_ready}, 4'b1100);

        set_ctl(32'h0000_0001);
        do_frame("R3 all zero", 0, 0, 0, 0, 3, 0, 1'b0);
        set_ctl(32'h8000_0008);
        do_frame("R7 max phases", 15, 15, 15, 15, 2, 1, 1'b0);
        set_ctl(32'h0000_0001);
        do_frame("R9 disturbed", 2, 1, 3, 2, 3, 0, 1'b1);

        for (int i = 0; i < 12; i++) begin
            int how = $urandom_range(0, 1);
            set_ctl(how == 0 ? 32'h0000_0001 : 32'h8000_0008);
            do_frame("R1 random", $urandom_range(0, 15), $urandom_range(0, 15),
                     $urandom_range(0, 15), $urandom_range(0, 15),
                     $urandom_range(1, 6), how, 1'b0);
        end

        // R10 interface disabled
        set_ctl(32'h8000_0009);
        @(negedge clk) cfg_word = 32'h0001_1110; frame_words = 4;
        expect_quiet("R10", "sw trigger with interface off", 0);
        expect_quiet("R10", "TE with interface off", 1);
        @(negedge clk) cfg_word = 32'h0001_1111;

        // R6 software mode off
        set_ctl(32'h0000_0000);
        expect_quiet("R6", "sw command with mode bit clear", 0);
        // R7 TE disabled and masked
        expect_quiet("R7", "TE with hw enable clear", 1);
        set_ctl(32'h8000_0018);
        expect_quiet("R7", "TE while masked", 1);

        // R4 zero frame size
        set_ctl(32'h0000_0001);
        @(negedge clk) frame_words = 0;
        expect_quiet("R4", "trigger with zero words", 0);

        // R8 one-shot TE then re-arm; per-pulse TE twice
        set_ctl(32'h0000_0008);
        do_frame("R8 one-shot first", 1, 0, 1, 0, 1, 1, 1'b0);
        expect_quiet("R8", "second TE in one-shot mode", 1);
        set_ctl(32'h0000_0008);
        do_frame("R8 re-armed", 0, 1, 2, 1, 2, 1, 1'b0);
        set_ctl(32'h8000_0008);
        do_frame("R8 per-pulse a", 0, 0, 1, 1, 1, 1, 1'b0);
        do_frame("R8 per-pulse b", 1, 1, 1, 1, 2, 1, 1'b0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule